// File: doc/BRIEF.md
# Serial Programming-Mode Entry Detector

This block decides whether a target device switches from normal operation into its program/verify mode. It watches three pins: a reset/programming level line, a serial clock and a serial data line. Entry needs three things in sequence. First a short high pulse on the level line. Then, once a guard interval has passed since that pulse ended, a 32-bit key clocked in on the data line. Finally the level line is raised again and held. If the key matched, the block latches program/verify mode and drives the I/O tristate enable. After a settling interval it raises a ready flag, which tells the downstream command decoder that serial data may now be trusted. Dropping the level line leaves the mode at once.

All three pins are asynchronous to the system clock. They pass through a synchroniser, and edges are detected in the system clock domain. The guard and settling intervals are parameters counted in system clock cycles.

Top module: `prog_entry_detect`

## Requirements
- R1: After reset, mode_active, io_tristate and data_ready are all low.
- R2: A high pulse on prog_lvl, then a correct 32-bit key, then prog_lvl raised and held, sets mode_active and io_tristate high within 3 system clock cycles of the rise.
- R3: The key is 32'h4D434850, and its most significant bit is shifted first. A key bit is sampled from ser_dat on each rising edge of ser_clk. A key that differs in any single bit leaves mode_active low after prog_lvl is raised and held.
- R4: If the key is sent while prog_lvl has been low since reset, with no pulse before it, raising prog_lvl does not enter the mode.
- R5: A ser_clk rising edge that arrives fewer than GUARD_CYC cycles after prog_lvl falls is discarded, and it clears any partial key. A full correct key sent after the guard interval still enters the mode.
- R6: A new prog_lvl pulse in the middle of a key restarts key collection. A full key after that new pulse enters the mode.
- R7: A key of fewer than 32 bits, followed by raising prog_lvl, does not enter the mode.
- R8: data_ready rises exactly SETTLE_CYC cycles after mode_active rises, and it is never high while mode_active is low.
- R9: io_tristate is high exactly when mode_active is high.
- R10: Dropping prog_lvl while in the mode clears all three outputs within 3 cycles. A later rise of prog_lvl, without a new entry sequence, leaves the device in normal mode.
- R11: A pulse on prog_lvl only one system clock cycle wide is enough as the first step of entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_lvl | input | 1 | Reset/programming level line (asynchronous) |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data line carrying the key (asynchronous) |
| mode_active | output | 1 | Program/verify mode is latched |
| io_tristate | output | 1 | Places unused I/O in high impedance |
| data_ready | output | 1 | Settling interval after entry has elapsed |

## Verification
The bench sends the key with each of its 32 bits flipped in turn. A design that compares only part of the key, or shifts least significant bit first, would enter the mode on a wrong key or refuse the right one. It sends an early clock edge just after the pulse, and breaks a key halfway with a new pulse. A design that keeps the stray or stale bits would count 33 bits, or mismatch, and fail to enter. It measures the cycle count from mode_active to data_ready and checks the one-cycle pulse, a missing pulse, a short key and a re-raise after exit. These catch an off-by-one settle timer, entry without the handshake, and a mode that survives release of the line.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [2:0] {
    PE_IDLE   = 3'd0,
    PE_PULSE  = 3'd1,
    PE_GAP    = 3'd2,
    PE_ARMED  = 3'd3,
    PE_ACTIVE = 3'd4
  } pe_state_e;

endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pe_key_shift.sv
module pe_key_shift #(
  parameter int               KEY_W     = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = 32'h4D434850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic full,
  output logic match
);

  localparam int CW = $clog2(KEY_W + 1);
  localparam logic [CW-1:0] FULL_V = CW'(KEY_W);

  logic [KEY_W-1:0] sr_q, sr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  // A clear wins over a shift; shifts stop once the count is full.
  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift_en && !full) begin
      sr_d  = {sr_q[KEY_W-2:0], bit_in};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign full  = (cnt_q == FULL_V);
  assign match = (sr_q == KEY_VALUE);

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int GUARD_CYC  = 20,
  parameter int SETTLE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_s,
  input  logic sclk_s,
  input  logic key_full,
  input  logic key_match,
  output logic shift_en,
  output logic key_clr,
  output logic mode_active,
  output logic data_ready
);

  localparam int TMAX = (GUARD_CYC > SETTLE_CYC) ? GUARD_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] GUARD_V  = TW'(GUARD_CYC);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC);

  pe_state_e     state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          lvl_prev_q, sclk_prev_q;
  logic          lvl_rise, lvl_fall, sclk_rise;

  assign lvl_rise  = lvl_s & ~lvl_prev_q;
  assign lvl_fall  = ~lvl_s & lvl_prev_q;
  assign sclk_rise = sclk_s & ~sclk_prev_q;

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    shift_en = 1'b0;
    key_clr  = 1'b0;
    unique case (state_q)
      PE_IDLE: begin
        if (lvl_rise) state_d = PE_PULSE;
      end
      PE_PULSE: begin
        if (lvl_fall) begin
          state_d = PE_GAP;
          tmr_d   = '0;
          key_clr = 1'b1;
        end
      end
      PE_GAP: begin
        if (tmr_q != GUARD_V) tmr_d = tmr_q + 1'b1;
        if (lvl_rise) begin
          state_d = PE_PULSE;
          key_clr = 1'b1;
        end else if (key_full) begin
          state_d = key_match ? PE_ARMED : PE_IDLE;
          key_clr = 1'b1;
        end else if (sclk_rise) begin
          if (tmr_q == GUARD_V) shift_en = 1'b1;
          else                  key_clr  = 1'b1;
        end
      end
      PE_ARMED: begin
        if (lvl_rise) begin
          state_d = PE_ACTIVE;
          tmr_d   = '0;
        end
      end
      PE_ACTIVE: begin
        if (lvl_fall) begin
          state_d = PE_IDLE;
        end else if (tmr_q != SETTLE_V) begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = PE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PE_IDLE;
      tmr_q       <= '0;
      lvl_prev_q  <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      tmr_q       <= tmr_d;
      lvl_prev_q  <= lvl_s;
      sclk_prev_q <= sclk_s;
    end
  end

  assign mode_active = (state_q == PE_ACTIVE);
  assign data_ready  = (state_q == PE_ACTIVE) && (tmr_q == SETTLE_V);

endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect #(
  parameter int               KEY_W       = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE   = 32'h4D434850,
  parameter int               GUARD_CYC   = 20,
  parameter int               SETTLE_CYC  = 40,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_lvl,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic mode_active,
  output logic io_tristate,
  output logic data_ready
);

  logic [2:0] pins_s;
  logic       lvl_s, sclk_s, dat_s;
  logic       shift_en, key_clr, key_full, key_match;

  pe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({prog_lvl, ser_clk, ser_dat}),
    .dout (pins_s)
  );

  assign {lvl_s, sclk_s, dat_s} = pins_s;

  pe_key_shift #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (key_clr),
    .shift_en(shift_en),
    .bit_in  (dat_s),
    .full    (key_full),
    .match   (key_match)
  );

  pe_ctrl #(.GUARD_CYC(GUARD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_s      (lvl_s),
    .sclk_s     (sclk_s),
    .key_full   (key_full),
    .key_match  (key_match),
    .shift_en   (shift_en),
    .key_clr    (key_clr),
    .mode_active(mode_active),
    .data_ready (data_ready)
  );

  assign io_tristate = mode_active;

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int SETTLE_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic lvl_s,
  input logic mode_active,
  input logic data_ready
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SET_V = CW'(SETTLE_CYC);

  // Cycles since mode_active went high, saturating at the settle limit.
  logic [CW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           age_q <= '0;
    else if (!mode_active)                age_q <= '0;
    else if (age_q != SET_V)              age_q <= age_q + 1'b1;
  end

  // R2: entry only follows a high level on the synchronised line
  a_r2_entry_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> $past(lvl_s));

  // R10: a low level ends the mode on the next cycle
  a_r10_exit_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && !lvl_s) |=> !mode_active);

  // R8: ready only inside the mode
  a_r8_ready_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> mode_active);

  // R8: ready rises exactly at the end of the settle window
  a_r8_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> (age_q == SET_V));

endmodule

bind prog_entry_detect pe_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_s      (lvl_s),
  .mode_active(mode_active),
  .data_ready (data_ready)
);

// File: tb/prog_entry_detect_tb.sv
module prog_entry_detect_tb;

  localparam int          GUARD  = 20;
  localparam int          SETTLE = 40;
  localparam logic [31:0] KEY    = 32'h4D434850;

  logic clk = 1'b0;
  logic rst_n;
  logic prog_lvl, ser_clk, ser_dat;
  logic mode_active, io_tristate, data_ready;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  prog_entry_detect #(.GUARD_CYC(GUARD), .SETTLE_CYC(SETTLE)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_lvl   (prog_lvl),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .mode_active(mode_active),
    .io_tristate(io_tristate),
    .data_ready (data_ready)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    tick(3);
    ser_clk = 1'b1;
    tick(3);
    ser_clk = 1'b0;
    tick(2);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 31; i > 31 - n; i--) send_bit(w[i]);
  endtask

  task automatic pulse(input int width);
    prog_lvl = 1'b1;
    tick(width);
    prog_lvl = 1'b0;
  endtask

  task automatic raise_and_settle();
    tick(4);
    prog_lvl = 1'b1;
    tick(3);
  endtask

  task automatic drop_line();
    prog_lvl = 1'b0;
    tick(6);
  endtask

  task automatic full_entry(input logic [31:0] k, input int pw);
    pulse(pw);
    tick(GUARD + 5);
    send_bits(k, 32);
    raise_and_settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    prog_lvl = 1'b0;
    ser_clk  = 1'b0;
    ser_dat  = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1: reset state
    check(mode_active, 1'b0, "R1 mode_active");
    check(io_tristate, 1'b0, "R1 io_tristate");
    check(data_ready,  1'b0, "R1 data_ready");

    // R4: key without a preceding pulse
    tick(GUARD + 5);
    send_bits(KEY, 32);
    raise_and_settle();
    tick(10);
    check(mode_active, 1'b0, "R4 no pulse");
    drop_line();

    // R2 / R8 / R9: valid entry and settle timing
    full_entry(KEY, 3);
    check(mode_active, 1'b1, "R2 mode_active");
    check(io_tristate, 1'b1, "R9 io_tristate on");
    check(data_ready,  1'b0, "R8 ready at entry");
    tick(SETTLE - 1);
    check(data_ready,  1'b0, "R8 ready one early");
    tick(1);
    check(data_ready,  1'b1, "R8 ready on time");

    // R10: exit, then a bare re-raise
    prog_lvl = 1'b0;
    tick(3);
    check(mode_active, 1'b0, "R10 exit mode");
    check(io_tristate, 1'b0, "R9 io_tristate off");
    check(data_ready,  1'b0, "R10 exit ready");
    tick(5);
    prog_lvl = 1'b1;
    tick(20);
    check(mode_active, 1'b0, "R10 re-raise normal");
    drop_line();

    // R3: every single-bit error is refused
    for (int i = 0; i < 32; i++) begin
      full_entry(KEY ^ (32'h1 << i), 2);
      tick(5);
      checks++;
      if (mode_active !== 1'b0 || io_tristate !== 1'b0) begin
        errors++;
        $display("FAIL R3 bit %0d: actual=%0b expected=0", i, mode_active);
      end
      drop_line();
    end

    // R3: bit order, reversed key must be refused
    full_entry({<<{KEY}}, 2);
    tick(5);
    check(mode_active, 1'b0, "R3 reversed key");
    drop_line();

    // R7: short key
    pulse(2);
    tick(GUARD + 5);
    send_bits(KEY, 31);
    raise_and_settle();
    tick(5);
    check(mode_active, 1'b0, "R7 short key");
    drop_line();

    // R5: early bit discarded
    pulse(2);
    tick(1);
    send_bit(1'b0);
    tick(GUARD + 5);
    send_bits(KEY, 32);
    raise_and_settle();
    check(mode_active, 1'b1, "R5 early bit dropped");
    drop_line();

    // R6: new pulse mid-key restarts collection
    pulse(2);
    tick(GUARD + 5);
    send_bits(KEY, 10);
    full_entry(KEY, 2);
    check(mode_active, 1'b1, "R6 restart on pulse");
    drop_line();

    // R11: one-cycle pulse
    full_entry(KEY, 1);
    check(mode_active, 1'b1, "R11 one-cycle pulse");
    check(io_tristate, 1'b1, "R11 io_tristate");

    // R8: exit during settle keeps ready low
    drop_line();
    full_entry(KEY, 2);
    tick(SETTLE / 2);
    prog_lvl = 1'b0;
    tick(SETTLE);
    check(data_ready, 1'b0, "R8 exit before settle");
    check(mode_active, 1'b0, "R10 exit before settle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule